// File: doc/BRIEF.md
# Address-Window FIFO Data Port

This block places a sample buffer behind a 256 KB bus address window that behaves as a FIFO rather than as memory. A read strobe decodes inside the window when the address matches the window base above bit 18. Such a read pops the oldest 32-bit longword from the sample buffer. The low 18 address bits are ignored, so a bus master may use incrementing addresses or repeat the same address and gets the same sequential stream.

Samples arrive one 16-bit value at a time from the acquisition side, in channel order starting at channel 1. A packer pairs each odd-numbered channel with the even-numbered channel after it to form one longword. Writes that decode inside the same window do not touch the sample buffer. They load a separate diagnostic FIFO, which drains on its own output port.

A pointer-reset strobe empties both FIFOs, realigns the packer and clears the error flags. It is meant to be applied before acquisition starts. Two sticky flags report a mismatch between the number of longwords read and the number produced:
- underflow: a read found the sample buffer empty;
- overflow: a packed longword arrived while the sample buffer was full.

Top module: `fifo_window_port`

## Requirements
- R1: A read strobe with the address inside the window pops the head longword of the sample buffer, and that longword appears on bus_rdata_o one clock after the strobe.
- R2: Address bits [17:0] have no effect: reads at incrementing, repeated or scattered offsets inside the window return the buffered longwords strictly in arrival order.
- R3: Samples pair in arrival order. The first sample of a pair (the odd-numbered channel) lands in bits [31:16] and the second (the even-numbered channel) in bits [15:0]. A longword enters the buffer only when the second sample arrives.
- R4: An access whose address bits [31:18] differ from the window base is ignored. It pops nothing, leaves bus_rdata_o unchanged and pushes nothing into the diagnostic FIFO.
- R5: A write strobe inside the window pushes bus_wdata_i into the diagnostic FIFO and leaves the sample buffer contents and order untouched.
- R6: A read inside the window while the sample buffer is empty returns 0 and sets underflow_o, which stays set until the pointer reset.
- R7: A longword that completes while the sample buffer is full is dropped and sets overflow_o, which stays set until the pointer reset. The buffered longwords are kept.
- R8: ptr_rst_i empties both FIFOs, discards a half-formed sample pair and clears both flags by the next clock.
- R9: The diagnostic FIFO shows its oldest entry on diag_data_o, advances on diag_pop_i, and reports diag_empty_o when it holds nothing.
- R10: After rst_ni, bus_rdata_o is 0, both flags are clear and diag_empty_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 32 | Byte address of the bus access |
| bus_rd_i | input | 1 | Read strobe, one cycle per longword |
| bus_wr_i | input | 1 | Write strobe, one cycle per longword |
| bus_wdata_i | input | 32 | Write data for the diagnostic FIFO |
| bus_rdata_o | output | 32 | Registered read data |
| smp_valid_i | input | 1 | Sample push strobe from acquisition |
| smp_data_i | input | 16 | Sample value |
| ptr_rst_i | input | 1 | Pointer and flag reset strobe |
| overflow_o | output | 1 | Sticky: packed longword dropped on full buffer |
| underflow_o | output | 1 | Sticky: read of empty buffer |
| diag_pop_i | input | 1 | Advance the diagnostic FIFO |
| diag_data_o | output | 32 | Head of the diagnostic FIFO |
| diag_empty_o | output | 1 | Diagnostic FIFO holds nothing |

## Verification
The bench targets these corner cases, each with the failure it would expose:
- Offset independence: reads at repeated, top-of-window and mid-window offsets must give one unbroken sequence. A design that indexed memory by address would return stale or skipped words.
- Window edges: reads just past the end and just before the base must leave data and pointers alone. A loose decode would silently eat a longword.
- Pointer reset with half a pair pending: a packer that keeps its phase would swap the two channel halves of every later longword.
- Buffer limits: reads from an empty buffer must return 0 and set underflow, and a push into a full buffer must be dropped and set overflow. A design that wrapped its pointers instead would corrupt the oldest data.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
  localparam int WORD_W = 32;
  localparam int SMP_W  = 16;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [SMP_W-1:0]  smp_t;

  typedef struct packed {
    logic rd;
    logic wr;
  } hit_t;
endpackage

// File: rtl/fwp_fifo.sv
module fwp_fifo #(
  parameter int W  = 32,
  parameter int AW = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o,
  output logic         drop_o
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] CNT_FULL = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign full_o  = (cnt == CNT_FULL);
  assign empty_o = (cnt == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign drop_o  = push_i & full_o;
  assign dout_o  = mem[rd_ptr];

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem[wr_ptr] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (flush_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/fwp_packer.sv
module fwp_packer
  import fwp_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  flush_i,
  input  logic  smp_valid_i,
  input  smp_t  smp_data_i,
  output logic  word_valid_o,
  output word_t word_o
);
  logic phase_q;  // 1: odd channel held, waiting for even
  smp_t hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      hi_q    <= '0;
    end else if (flush_i) begin
      phase_q <= 1'b0;
    end else if (smp_valid_i) begin
      phase_q <= ~phase_q;
      if (!phase_q) hi_q <= smp_data_i;
    end
  end

  assign word_valid_o = smp_valid_i & phase_q & ~flush_i;
  assign word_o       = {hi_q, smp_data_i};
endmodule

// File: rtl/fwp_decode.sv
module fwp_decode
  import fwp_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter int                WIN_LOG2 = 18,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h0010_0000
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output hit_t              hit_o
);
  localparam int TAG_W = ADDR_W - WIN_LOG2;
  localparam logic [TAG_W-1:0] BASE_TAG = WIN_BASE[ADDR_W-1:WIN_LOG2];

  logic in_win;
  assign in_win   = (addr_i[ADDR_W-1:WIN_LOG2] == BASE_TAG);
  assign hit_o.rd = rd_i & in_win;
  assign hit_o.wr = wr_i & in_win;
endmodule

// File: rtl/fifo_window_port.sv
module fifo_window_port
  import fwp_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          WIN_LOG2  = 18,
  parameter logic [31:0] WIN_BASE  = 32'h0010_0000,
  parameter int          SMP_AW    = 3,
  parameter int          DIAG_AW   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic              smp_valid_i,
  input  logic [15:0]       smp_data_i,
  input  logic              ptr_rst_i,
  output logic              overflow_o,
  output logic              underflow_o,
  input  logic              diag_pop_i,
  output logic [31:0]       diag_data_o,
  output logic              diag_empty_o
);
  hit_t  hit;
  logic  word_valid;
  word_t word;
  word_t smp_head;
  logic  smp_full, smp_empty, smp_drop;
  logic  diag_full, diag_drop;

  fwp_decode #(
    .ADDR_W  (ADDR_W),
    .WIN_LOG2(WIN_LOG2),
    .WIN_BASE(ADDR_W'(WIN_BASE))
  ) u_dec (
    .addr_i(bus_addr_i),
    .rd_i  (bus_rd_i),
    .wr_i  (bus_wr_i),
    .hit_o (hit)
  );

  fwp_packer u_pack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (ptr_rst_i),
    .smp_valid_i (smp_valid_i),
    .smp_data_i  (smp_data_i),
    .word_valid_o(word_valid),
    .word_o      (word)
  );

  fwp_fifo #(.W(WORD_W), .AW(SMP_AW)) u_smp_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(ptr_rst_i),
    .push_i (word_valid),
    .din_i  (word),
    .pop_i  (hit.rd),
    .dout_o (smp_head),
    .full_o (smp_full),
    .empty_o(smp_empty),
    .drop_o (smp_drop)
  );

  fwp_fifo #(.W(WORD_W), .AW(DIAG_AW)) u_diag_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(ptr_rst_i),
    .push_i (hit.wr),
    .din_i  (bus_wdata_i),
    .pop_i  (diag_pop_i),
    .dout_o (diag_data_o),
    .full_o (diag_full),
    .empty_o(diag_empty_o),
    .drop_o (diag_drop)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_rdata_o <= '0;
      overflow_o  <= 1'b0;
      underflow_o <= 1'b0;
    end else if (ptr_rst_i) begin
      overflow_o  <= 1'b0;
      underflow_o <= 1'b0;
    end else begin
      if (hit.rd) begin
        bus_rdata_o <= smp_empty ? '0 : smp_head;
        if (smp_empty) underflow_o <= 1'b1;
      end
      if (smp_drop) overflow_o <= 1'b1;
    end
  end

  logic unused_ok;
  assign unused_ok = smp_full ^ diag_full ^ diag_drop;
endmodule

// File: rtl/fifo_window_port_chk.sv
module fifo_window_port_chk #(
  parameter int          ADDR_W   = 32,
  parameter int          WIN_LOG2 = 18,
  parameter logic [31:0] WIN_BASE = 32'h0010_0000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_rd_i,
  input logic [31:0]       bus_rdata_o,
  input logic              ptr_rst_i,
  input logic              overflow_o,
  input logic              underflow_o,
  input logic              diag_empty_o
);
  logic in_win;
  assign in_win = (bus_addr_i >> WIN_LOG2) == (ADDR_W'(WIN_BASE) >> WIN_LOG2);

  // R4
  outside_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && !in_win) |=> $stable(bus_rdata_o));

  // R6
  underflow_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underflow_o && !ptr_rst_i) |=> underflow_o);

  // R6
  underflow_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(underflow_o) |-> $past(bus_rd_i && in_win));

  // R7
  overflow_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o && !ptr_rst_i) |=> overflow_o);

  // R8
  ptr_rst_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_rst_i |=> (!overflow_o && !underflow_o && diag_empty_o));
endmodule

bind fifo_window_port fifo_window_port_chk #(
  .ADDR_W  (ADDR_W),
  .WIN_LOG2(WIN_LOG2),
  .WIN_BASE(WIN_BASE)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_addr_i  (bus_addr_i),
  .bus_rd_i    (bus_rd_i),
  .bus_rdata_o (bus_rdata_o),
  .ptr_rst_i   (ptr_rst_i),
  .overflow_o  (overflow_o),
  .underflow_o (underflow_o),
  .diag_empty_o(diag_empty_o)
);

// File: tb/fifo_window_port_tb.sv
`timescale 1ns/1ps
module fifo_window_port_tb;
  localparam logic [31:0] BASE  = 32'h0010_0000;
  localparam int          DEPTH = 8;

  logic        clk_i = 0, rst_ni = 0;
  logic [31:0] bus_addr_i = '0, bus_wdata_i = '0;
  logic        bus_rd_i = 0, bus_wr_i = 0;
  logic [31:0] bus_rdata_o;
  logic        smp_valid_i = 0;
  logic [15:0] smp_data_i = '0;
  logic        ptr_rst_i = 0;
  logic        overflow_o, underflow_o;
  logic        diag_pop_i = 0;
  logic [31:0] diag_data_o;
  logic        diag_empty_o;

  int errors = 0, checks = 0;
  bit done = 0;

  // model
  logic [31:0] mq[$];
  logic [31:0] dq[$];
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] last_rd = '0;
  logic [15:0] m_hi = '0;
  bit          m_ph = 0, m_ovf = 0, m_udf = 0;

  always #4 clk_i = ~clk_i;

  fifo_window_port u_dut (.*);

  function automatic bit in_win(logic [31:0] a);
    return (a >> 18) == (BASE >> 18);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push_smp(logic [15:0] v);
    @(negedge clk_i);
    smp_valid_i = 1; smp_data_i = v;
    if (!m_ph) begin m_hi = v; m_ph = 1; end
    else begin
      m_ph = 0;
      if (mq.size() < DEPTH) mq.push_back({m_hi, v});
      else m_ovf = 1;
    end
    @(negedge clk_i);
    smp_valid_i = 0;
  endtask

  task automatic push_pair(logic [15:0] a, logic [15:0] b);
    push_smp(a); push_smp(b);
  endtask

  task automatic rd_word(logic [31:0] a, string tag);
    logic [31:0] e;
    @(negedge clk_i);
    if (in_win(a)) begin
      if (mq.size() > 0) e = mq.pop_front();
      else begin e = '0; m_udf = 1; end
      last_rd = e;
    end else e = last_rd;
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_addr_i = a; bus_rd_i = 1;
    @(negedge clk_i);
    bus_rd_i = 0;
  endtask

  task automatic wr_word(logic [31:0] a, logic [31:0] d);
    @(negedge clk_i);
    bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1;
    if (in_win(a) && dq.size() < 4) dq.push_back(d);
    @(negedge clk_i);
    bus_wr_i = 0;
  endtask

  task automatic ptr_reset();
    @(negedge clk_i);
    ptr_rst_i = 1;
    mq.delete(); dq.delete(); m_ph = 0; m_ovf = 0; m_udf = 0;
    @(negedge clk_i);
    ptr_rst_i = 0;
  endtask

  task automatic check_flags(string tag);
    @(negedge clk_i);
    check({tag, " overflow"}, 32'(overflow_o), 32'(m_ovf));
    check({tag, " underflow"}, 32'(underflow_o), 32'(m_udf));
  endtask

  // monitor: compares each read result one clock after its strobe
  always @(posedge clk_i) begin
    #1;
    if (exp_q.size() > 0) check(tag_q.pop_front(), bus_rdata_o, exp_q.pop_front());
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R10
    check("R10 rdata", bus_rdata_o, 32'h0);
    check("R10 overflow", 32'(overflow_o), 32'h0);
    check("R10 underflow", 32'(underflow_o), 32'h0);
    check("R10 diag_empty", 32'(diag_empty_o), 32'h1);
    rst_ni = 1;
    ptr_reset();

    // R1 R3: channel order, R2 repeated address
    push_pair(16'h1001, 16'h2002);
    push_pair(16'h3003, 16'h4004);
    rd_word(BASE, "R1 R3 first word");
    rd_word(BASE, "R2 repeated address");

    // R2: scattered offsets
    push_pair(16'hA001, 16'hA002);
    push_pair(16'hA003, 16'hA004);
    push_pair(16'hA005, 16'hA006);
    rd_word(BASE + 32'h4, "R2 offset 4");
    rd_word(BASE + 32'h3FFFC, "R2 top offset");
    rd_word(BASE + 32'h100, "R2 mid offset");

    // R4: outside the window
    push_pair(16'hB001, 16'hB002);
    rd_word(BASE + 32'h40000, "R4 past end");
    rd_word(BASE - 32'h4, "R4 below base");
    wr_word(BASE + 32'h40000, 32'hDEAD_0000);
    rd_word(BASE + 32'h8, "R4 no pop");

    // R6: empty read
    rd_word(BASE, "R6 empty read");
    check_flags("R6");
    push_pair(16'hC001, 16'hC002);
    check_flags("R6 sticky");

    // R5 R9: diagnostic writes do not disturb samples
    wr_word(BASE, 32'h1111_0001);
    wr_word(BASE + 32'h20, 32'h1111_0002);
    wr_word(BASE + 32'h3FFF0, 32'h1111_0003);
    rd_word(BASE + 32'hC, "R5 sample after diag writes");
    @(negedge clk_i);
    check("R9 diag not empty", 32'(diag_empty_o), 32'h0);
    while (dq.size() > 0) begin
      check("R9 R4 diag order", diag_data_o, dq.pop_front());
      diag_pop_i = 1;
      @(negedge clk_i);
      diag_pop_i = 0;
    end
    check("R9 diag drained", 32'(diag_empty_o), 32'h1);

    // R8: pointer reset with a half pair pending
    push_pair(16'hD001, 16'hD002);
    wr_word(BASE, 32'h2222_0001);
    push_smp(16'hEEEE);
    ptr_reset();
    check_flags("R8");
    @(negedge clk_i);
    check("R8 diag emptied", 32'(diag_empty_o), 32'h1);
    push_pair(16'hF001, 16'hF002);
    rd_word(BASE, "R8 R3 realigned pair");
    rd_word(BASE, "R8 buffer emptied");
    ptr_reset();

    // R7: overflow
    for (int i = 0; i < DEPTH + 2; i++) push_pair(16'(16'h5000 + i), 16'(16'h6000 + i));
    check_flags("R7");
    for (int i = 0; i < DEPTH; i++) rd_word(BASE + 32'(i * 4), "R7 kept order");
    rd_word(BASE, "R6 R7 empty after drain");
    check_flags("R7 R6 end");

    repeat (3) @(negedge clk_i);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule